// File: doc/BRIEF.md
# Two-Channel Serial Bridge SPI Register Slave

This block is the host-facing front end of a two-channel serial bridge. A host talks to it over a four-wire SPI link in mode 0. The block turns each framed transaction into strobes for the bridge's register file. The first byte of every frame is a command. It names the access direction, one of sixteen registers and one of two channels. A plain register access is one command byte followed by one data byte. When the command addresses register 0, the frame becomes a stream instead. Every further byte moves to or from the selected channel's transmit or receive FIFO until chip select is released.

All SPI pins are brought into the system clock domain through synchronizers, and the slave works on the detected SCK edges. Two registers are answered inside the block from the FIFO level inputs: the free space in the transmit FIFO and the fill of the receive FIFO. Every other read uses the register file's combinational read data. For register 0, that read data is the head of the receive FIFO, and a read strobe pops it. The SCK period must be at least ten system clock periods.

Top module: `spi_reg_slave`

## Requirements
- R1: In the command byte (the first byte after chip select falls), bit 7 selects read (1) or write (0), bits 6:3 give the register address and bit 1 the channel; bits 2 and 0 have no effect on the access.
- R2: A write to a nonzero register takes exactly two bytes. When the second byte is complete, reg_we pulses once with that byte on reg_wdata and the decoded address and channel. Any further bytes in the same frame produce no strobe.
- R3: A read of a nonzero register drives the register value on spi_miso during the second byte, MSB first. spi_miso changes after falling SCK edges and is valid at rising edges.
- R4: A write command to register 0 pushes every complete following byte into the selected channel's TX FIFO, as one reg_we pulse on address 0 per byte, until chip select rises.
- R5: In a register 0 write stream, a byte that arrives while the selected TX level equals the FIFO depth is dropped without a strobe.
- R6: A read command to register 0 returns the selected channel's RX FIFO bytes in order on successive bytes. Each byte is popped by one reg_re pulse on address 0 once the byte has been fully clocked out.
- R7: In a register 0 read stream, a byte slot that starts while the RX FIFO is empty returns 0x00 and issues no pop.
- R8: Register 8 reads return the FIFO depth minus the selected TX level. Register 9 reads return the selected RX level. Neither issues reg_re.
- R9: When chip select rises part way through a byte, that byte causes no write strobe and no pop. A partly clocked RX byte stays at the FIFO head.
- R10: During reset, and whenever chip select has been high for 12 or more clock cycles, spi_miso is 0 and neither strobe is active.
- R11: reg_we and reg_re are single-cycle pulses that never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_addr | output | 4 | Decoded register address |
| reg_chan | output | 1 | Decoded channel |
| reg_wdata | output | 8 | Write data / FIFO push data |
| reg_we | output | 1 | Write or push strobe |
| reg_re | output | 1 | Read or pop strobe |
| reg_rdata | input | 8 | Combinational read data of the addressed register (RX head for address 0) |
| tx_level | input | 2*LVL_W | TX FIFO fill per channel, channel 1 in the upper half |
| rx_level | input | 2*LVL_W | RX FIFO fill per channel, channel 1 in the upper half |

## Verification
In a receive stream, two actions fall in the same stretch: the pop of the byte that has just finished, and the fetch of the next byte to shift out. The fetch must see the FIFO after the pop. The bench streams several queued bytes back to back, reads one more slot than there are bytes, and judges that each byte arrives once and in order, that the last slot is 0x00, and that the pop count equals the number of real bytes. A second case is a chip select that rises while a byte is in flight, during both a receive stream and a single write. The bench judges it by the level counters and by a later stream that still returns the unconsumed byte.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  localparam int BYTE_W = 8;

  localparam logic [3:0] ADDR_STREAM = 4'h0;
  localparam logic [3:0] ADDR_TXFREE = 4'h8;
  localparam logic [3:0] ADDR_RXFILL = 4'h9;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_SINGLE,
    PH_BURST,
    PH_DONE
  } phase_e;

  typedef struct packed {
    logic       rd;
    logic [3:0] addr;
    logic       chan;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
    cmd_t c;
    c.rd   = b[7];
    c.addr = b[6:3];
    c.chan = b[1];
    return c;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_active,
  output logic mosi_s
);

  logic [STAGES-1:0] sck_p, cs_p, mosi_p;
  logic              sck_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p    <= '0;
      cs_p     <= '1;
      mosi_p   <= '0;
      sck_last <= 1'b0;
    end else begin
      sck_p    <= {sck_p[STAGES-2:0], sck};
      cs_p     <= {cs_p[STAGES-2:0], cs_n};
      mosi_p   <= {mosi_p[STAGES-2:0], mosi};
      sck_last <= sck_p[STAGES-1];
    end
  end

  assign cs_active = ~cs_p[STAGES-1];
  assign mosi_s    = mosi_p[STAGES-1];
  assign sck_rise  = cs_active &  sck_p[STAGES-1] & ~sck_last;
  assign sck_fall  = cs_active & ~sck_p[STAGES-1] &  sck_last;

endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx
  import spi_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              sck_rise,
  input  logic              mosi_s,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);

  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-2:0] sh_q, sh_d;
  logic              done_q, done_d;
  logic [BYTE_W-1:0] val_q, val_d;

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    val_d  = val_q;
    if (!cs_active) begin
      cnt_d = '0;
    end else if (sck_rise) begin
      sh_d  = {sh_q[BYTE_W-3:0], mosi_s};
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(BYTE_W - 1)) begin
        done_d = 1'b1;
        val_d  = {sh_q, mosi_s};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      val_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      done_q <= done_d;
      if (done_d) val_q <= val_d;
    end
  end

  assign byte_done = done_q;
  assign byte_val  = val_q;

endmodule

// File: rtl/spi_byte_tx.sv
module spi_byte_tx
  import spi_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              sck_fall,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  output logic              miso
);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              miso_q, miso_d;

  always_comb begin
    sh_d   = sh_q;
    miso_d = miso_q;
    if (!cs_active) begin
      sh_d   = '0;
      miso_d = 1'b0;
    end else if (load) begin
      sh_d = load_val;
    end else if (sck_fall) begin
      miso_d = sh_q[BYTE_W-1];
      sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      miso_q <= miso_d;
    end
  end

  assign miso = miso_q;

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_bridge_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter int SYNC_STAGES = 2,
  parameter int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sck,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  output logic               spi_miso,
  output logic [3:0]         reg_addr,
  output logic               reg_chan,
  output logic [BYTE_W-1:0]  reg_wdata,
  output logic               reg_we,
  output logic               reg_re,
  input  logic [BYTE_W-1:0]  reg_rdata,
  input  logic [2*LVL_W-1:0] tx_level,
  input  logic [2*LVL_W-1:0] rx_level
);

  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(FIFO_DEPTH);

  logic sck_rise, sck_fall, cs_active, mosi_s;
  logic byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic tx_load;
  logic [BYTE_W-1:0] tx_load_val;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_active(cs_active), .mosi_s(mosi_s)
  );

  spi_byte_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .sck_rise(sck_rise),
    .mosi_s(mosi_s), .byte_done(byte_done), .byte_val(byte_val)
  );

  spi_byte_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .sck_fall(sck_fall),
    .load(tx_load), .load_val(tx_load_val), .miso(spi_miso)
  );

  phase_e            phase_q, phase_d;
  logic              rd_q, rd_d;
  logic [3:0]        addr_q, addr_d;
  logic              chan_q, chan_d;
  logic              pend1_q, pend1_d, pend2_q, pend2_d;
  logic              head_ok_q, head_ok_d;
  logic              we_q, we_d, re_q, re_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d;

  logic [LVL_W-1:0] cur_tx, cur_rx, tx_free;
  logic             tx_room, rx_any;
  cmd_t             cmd;

  assign cur_tx  = chan_q ? tx_level[2*LVL_W-1:LVL_W] : tx_level[LVL_W-1:0];
  assign cur_rx  = chan_q ? rx_level[2*LVL_W-1:LVL_W] : rx_level[LVL_W-1:0];
  assign tx_free = DEPTH_L - cur_tx;
  assign tx_room = cur_tx < DEPTH_L;
  assign rx_any  = cur_rx != '0;
  assign cmd     = decode_cmd(byte_val);

  always_comb begin
    phase_d     = phase_q;
    rd_d        = rd_q;
    addr_d      = addr_q;
    chan_d      = chan_q;
    pend1_d     = 1'b0;
    pend2_d     = pend1_q;
    head_ok_d   = head_ok_q;
    we_d        = 1'b0;
    re_d        = 1'b0;
    wdata_d     = wdata_q;
    tx_load     = 1'b0;
    tx_load_val = '0;

    if (byte_done) begin
      unique case (phase_q)
        PH_CMD: begin
          rd_d    = cmd.rd;
          addr_d  = cmd.addr;
          chan_d  = cmd.chan;
          phase_d = (cmd.addr == ADDR_STREAM) ? PH_BURST : PH_SINGLE;
          pend1_d = cmd.rd;
        end
        PH_SINGLE: begin
          phase_d = PH_DONE;
          if (!rd_q) begin
            we_d    = 1'b1;
            wdata_d = byte_val;
          end
        end
        PH_BURST: begin
          if (rd_q) begin
            re_d      = head_ok_q;
            head_ok_d = 1'b0;
            pend1_d   = 1'b1;
          end else if (tx_room) begin
            we_d    = 1'b1;
            wdata_d = byte_val;
          end
        end
        default: ;
      endcase
    end

    if (pend2_q) begin
      tx_load = 1'b1;
      if (phase_q == PH_BURST) begin
        tx_load_val = rx_any ? reg_rdata : '0;
        head_ok_d   = rx_any;
      end else if (addr_q == ADDR_TXFREE) begin
        tx_load_val = BYTE_W'(tx_free);
      end else if (addr_q == ADDR_RXFILL) begin
        tx_load_val = BYTE_W'(cur_rx);
      end else begin
        tx_load_val = reg_rdata;
        re_d        = 1'b1;
      end
    end

    if (!cs_active) begin
      phase_d   = PH_CMD;
      pend1_d   = 1'b0;
      pend2_d   = 1'b0;
      head_ok_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_CMD;
      rd_q      <= 1'b0;
      addr_q    <= '0;
      chan_q    <= 1'b0;
      pend1_q   <= 1'b0;
      pend2_q   <= 1'b0;
      head_ok_q <= 1'b0;
      we_q      <= 1'b0;
      re_q      <= 1'b0;
      wdata_q   <= '0;
    end else begin
      phase_q   <= phase_d;
      pend1_q   <= pend1_d;
      pend2_q   <= pend2_d;
      head_ok_q <= head_ok_d;
      we_q      <= we_d;
      re_q      <= re_d;
      if (byte_done && phase_q == PH_CMD) begin
        rd_q   <= rd_d;
        addr_q <= addr_d;
        chan_q <= chan_d;
      end
      if (we_d) wdata_q <= wdata_d;
    end
  end

  assign reg_addr  = addr_q;
  assign reg_chan  = chan_q;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;
  assign reg_re    = re_q;

endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int FIFO_DEPTH = 64,
  parameter int LVL_W      = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               spi_cs_n,
  input logic               spi_miso,
  input logic [3:0]         reg_addr,
  input logic               reg_chan,
  input logic               reg_we,
  input logic               reg_re,
  input logic [2*LVL_W-1:0] tx_level,
  input logic [2*LVL_W-1:0] rx_level,
  input logic               tx_load,
  input logic               sck_fall
);

  logic [LVL_W-1:0] sel_tx, sel_rx;
  logic [3:0]       idle_cnt;

  assign sel_tx = reg_chan ? tx_level[2*LVL_W-1:LVL_W] : tx_level[LVL_W-1:0];
  assign sel_rx = reg_chan ? rx_level[2*LVL_W-1:LVL_W] : rx_level[LVL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_cnt <= '0;
    else if (!spi_cs_n) idle_cnt <= '0;
    else if (idle_cnt != 4'hF) idle_cnt <= idle_cnt + 4'd1;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re)); // R11
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R11
  AST_RE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re); // R11
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'h0) |-> (sel_tx < LVL_W'(FIFO_DEPTH))); // R5
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == 4'h0) |-> (sel_rx != '0)); // R7
  AST_LEVEL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |-> (reg_addr != 4'h8 && reg_addr != 4'h9)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt >= 4'd12) |-> (!reg_we && !reg_re && !spi_miso)); // R10
  AST_LOAD_CLEAR_OF_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_load && sck_fall)); // R3

endmodule

bind spi_reg_slave spi_reg_slave_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .reg_addr(reg_addr), .reg_chan(reg_chan), .reg_we(reg_we), .reg_re(reg_re),
  .tx_level(tx_level), .rx_level(rx_level), .tx_load(tx_load), .sck_fall(sck_fall)
);

// File: tb/tb_spi_reg_slave.sv
module tb_spi_reg_slave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int DEPTH      = 64;
  localparam int LVL_W      = 7;
  localparam int NVEC       = 7;

  // {is_read, command, data byte, expected}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 8'h18, 8'h5A, 8'h5A},
    {1'b0, 8'h3F, 8'hC3, 8'hC3},
    {1'b0, 8'h7A, 8'h01, 8'h01},
    {1'b1, 8'hA8, 8'h00, 8'h25},
    {1'b1, 8'hAF, 8'hFF, 8'hA5},
    {1'b1, 8'hF2, 8'h00, 8'hAE},
    {1'b1, 8'h88, 8'h3C, 8'h21}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso;
  logic [3:0] reg_addr;
  logic reg_chan, reg_we, reg_re;
  logic [7:0] reg_wdata, reg_rdata;
  logic [2*LVL_W-1:0] tx_level, rx_level;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
    .reg_chan(reg_chan), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata), .tx_level(tx_level),
    .rx_level(rx_level)
  );

  // register file and FIFO model
  logic [7:0] rx_mem [2][DEPTH];
  logic [7:0] push_log [2][DEPTH];
  int rx_wr [2] = '{0, 0};
  int rx_rd [2] = '{0, 0};
  int tx_cnt [2] = '{0, 0};
  int tx_bias [2] = '{0, 0};
  int we_cnt = 0, re_cnt = 0, we_hi = 0;
  logic [3:0] we_addr = '0;
  logic we_chan = 1'b0;
  logic [7:0] we_data = '0;
  int n_chk = 0, n_err = 0;

  assign tx_level = {LVL_W'(tx_cnt[1] + tx_bias[1]), LVL_W'(tx_cnt[0] + tx_bias[0])};
  assign rx_level = {LVL_W'(rx_wr[1] - rx_rd[1]), LVL_W'(rx_wr[0] - rx_rd[0])};

  always_comb begin
    if (reg_addr == 4'h0)
      reg_rdata = (rx_rd[reg_chan] < rx_wr[reg_chan]) ? rx_mem[reg_chan][rx_rd[reg_chan] % DEPTH] : 8'h00;
    else
      reg_rdata = {reg_chan, 3'b010, reg_addr};
  end

  always @(posedge clk) begin
    if (reg_we) begin
      we_hi <= we_hi + 1;
      if (reg_addr == 4'h0) begin
        push_log[reg_chan][tx_cnt[reg_chan] % DEPTH] <= reg_wdata;
        tx_cnt[reg_chan] <= tx_cnt[reg_chan] + 1;
      end else begin
        we_cnt  <= we_cnt + 1;
        we_addr <= reg_addr;
        we_chan <= reg_chan;
        we_data <= reg_wdata;
      end
    end
    if (reg_re) begin
      re_cnt <= re_cnt + 1;
      if (reg_addr == 4'h0 && rx_rd[reg_chan] < rx_wr[reg_chan])
        rx_rd[reg_chan] <= rx_rd[reg_chan] + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cs_lo();
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] o, output logic [7:0] i, input int nbits);
    i = 8'h00;
    for (int b = 7; b >= 8 - nbits; b--) begin
      spi_mosi = o[b];
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b1;
      i[b] = spi_miso;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] got, dummy;
    int snap_we, snap_re, snap_hi;
    rst_n = 1'b0; spi_sck = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10", "miso in reset", int'(spi_miso), 0);
    chk("R10", "strobes in reset", int'({reg_we, reg_re}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // table of single accesses
    for (int k = 0; k < NVEC; k++) begin
      logic isr;
      logic [7:0] c, d, e;
      {isr, c, d, e} = VEC[k];
      snap_we = we_cnt; snap_re = re_cnt;
      cs_lo();
      xfer(c, dummy, 8);
      xfer(d, got, 8);
      cs_hi();
      if (isr) begin
        chk("R3", "single read byte", int'(got), int'(e));
        chk("R3", "single read strobe count", re_cnt - snap_re, 1);
      end else begin
        chk("R2", "single write strobe count", we_cnt - snap_we, 1);
        chk("R2", "single write data", int'(we_data), int'(e));
        chk("R1", "decoded address", int'(we_addr), int'(c[6:3]));
        chk("R1", "decoded channel", int'(we_chan), int'(c[1]));
      end
    end

    // extra bytes after a single write are ignored
    snap_we = we_cnt;
    cs_lo();
    xfer(8'h20, dummy, 8); xfer(8'h77, dummy, 8); xfer(8'h99, dummy, 8); xfer(8'h55, dummy, 8);
    cs_hi();
    chk("R2", "strobes with trailing bytes", we_cnt - snap_we, 1);
    chk("R2", "data with trailing bytes", int'(we_data), 8'h77);

    // TX stream on channel 0
    snap_hi = we_hi;
    cs_lo();
    xfer(8'h00, dummy, 8); xfer(8'h11, dummy, 8); xfer(8'h22, dummy, 8); xfer(8'h33, dummy, 8);
    cs_hi();
    chk("R4", "pushed count ch0", tx_cnt[0], 3);
    chk("R4", "push 0", int'(push_log[0][0]), 8'h11);
    chk("R4", "push 1", int'(push_log[0][1]), 8'h22);
    chk("R4", "push 2", int'(push_log[0][2]), 8'h33);
    chk("R11", "write strobe cycles for three pushes", we_hi - snap_hi, 3);

    // level registers
    rx_mem[1][0] = 8'hD1; rx_mem[1][1] = 8'hD2; rx_mem[1][2] = 8'hD3; rx_wr[1] = 3;
    snap_re = re_cnt;
    cs_lo(); xfer(8'hC0, dummy, 8); xfer(8'h00, got, 8); cs_hi();
    chk("R8", "TX free ch0", int'(got), DEPTH - 3);
    cs_lo(); xfer(8'hCA, dummy, 8); xfer(8'h00, got, 8); cs_hi();
    chk("R8", "RX fill ch1", int'(got), 3);
    chk("R8", "no read strobe for level regs", re_cnt - snap_re, 0);

    // RX stream on channel 1, one slot beyond the data
    snap_re = re_cnt;
    cs_lo();
    xfer(8'h82, dummy, 8);
    xfer(8'h00, got, 8); chk("R6", "rx byte 0", int'(got), 8'hD1);
    xfer(8'h00, got, 8); chk("R6", "rx byte 1", int'(got), 8'hD2);
    xfer(8'h00, got, 8); chk("R6", "rx byte 2", int'(got), 8'hD3);
    xfer(8'h00, got, 8); chk("R7", "empty slot", int'(got), 0);
    cs_hi();
    chk("R6", "consumed ch1", rx_rd[1], 3);
    chk("R7", "pops equal real bytes", re_cnt - snap_re, 3);
    chk("R6", "ch0 untouched", rx_rd[0], 0);

    // TX stream into a nearly full FIFO on channel 1
    tx_bias[1] = DEPTH - 1;
    cs_lo();
    xfer(8'h02, dummy, 8); xfer(8'hE1, dummy, 8); xfer(8'hE2, dummy, 8); xfer(8'hE3, dummy, 8);
    cs_hi();
    chk("R5", "pushes when full", tx_cnt[1], 1);
    chk("R5", "accepted byte", int'(push_log[1][0]), 8'hE1);

    // chip select rises within a byte
    snap_we = we_cnt;
    cs_lo(); xfer(8'h18, dummy, 8); xfer(8'hAB, dummy, 4); cs_hi();
    chk("R9", "no write on partial byte", we_cnt - snap_we, 0);
    rx_mem[0][0] = 8'h61; rx_mem[0][1] = 8'h62; rx_wr[0] = 2;
    cs_lo(); xfer(8'h80, dummy, 8); xfer(8'h00, got, 8); xfer(8'h00, dummy, 3); cs_hi();
    chk("R6", "first ch0 byte", int'(got), 8'h61);
    chk("R9", "partial byte not popped", rx_rd[0], 1);
    cs_lo(); xfer(8'h80, dummy, 8); xfer(8'h00, got, 8); cs_hi();
    chk("R9", "partial byte still at head", int'(got), 8'h62);

    chk("R10", "miso idle", int'(spi_miso), 0);
    chk("R10", "strobes idle", int'({reg_we, reg_re}), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule